// File: doc/BRIEF.md
# Two-Segment Active-Vector Switching Sequencer

This block produces the three upper-switch commands of a three-phase voltage-source inverter leg set, plus their complements, over a fixed sampling period of `PERIOD_TICKS` timer ticks. Each period has two segments. The first segment holds one active vector for a programmable number of ticks. The second segment holds another active vector for the rest of the period. The outputs never take the two zero states, so the common-mode level always stays at plus or minus one sixth of the DC link. The block also reports the sign of that level for the current state.

A predictive controller sends the next vector pair and the first-segment length as one command on a valid/ready interface. The block keeps one accepted command in a holding register, and `cmd_ready` stays low while that register is full. The held command is applied at the next period boundary. A command accepted in the middle of a period therefore never disturbs the period already running. If no new command arrives before a boundary, the previous pair and split repeat. Back-pressure lasts at most until the next boundary. A producer that keeps `cmd_valid` high with stable data while `cmd_ready` is low loses nothing.

Top module: `dualvec_sequencer`

## Requirements
- R1: Vector indices 1 to 6 drive `sw_hi` = {A,B,C} to 100, 110, 010, 011, 001 and 101 respectively, where bit 2 is phase A and a 1 means the upper switch is closed.
- R2: `sw_hi` is never 000 or 111, in any cycle, including during and right after reset.
- R3: A period lasts `PERIOD_TICKS` clock edges that have `tick` high. With a split of T1, the first vector is output for T1 ticks and the second for the remaining ticks. On edges where `tick` is low, the outputs and the strobe do not change.
- R4: `period_start` is high for exactly one clock, in the same cycle that `sw_hi` first shows the first vector of a new period.
- R5: A command is accepted on a clock edge with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is then low until the next period boundary, where the command takes effect. The period in progress finishes with its old pair and split.
- R6: When no command is pending at a boundary, the previous pair and split repeat unchanged.
- R7: A split of 0 is applied as 1. A split at or above `PERIOD_TICKS` is applied as `PERIOD_TICKS`-1.
- R8: An index of 0 or 7 is illegal. When a segment with an illegal index starts, `sw_hi` keeps the vector it already shows.
- R9: `sw_lo` is always the bitwise inverse of `sw_hi`.
- R10: `cm_pos` is 1 when exactly two upper switches are closed and 0 when exactly one is closed.
- R11: After reset, `sw_hi` is 100, `period_start` is 0 and `cmd_ready` is 1. The first period runs vector 1 in both segments, with a split of `PERIOD_TICKS`/2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer tick enable; one period is PERIOD_TICKS ticks |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Holding register empty; a command can be accepted |
| cmd_first | input | 3 | Index of the first-segment vector |
| cmd_second | input | 3 | Index of the second-segment vector |
| cmd_t1 | input | $clog2(PERIOD_TICKS) | Requested first-segment length in ticks |
| sw_hi | output | 3 | Upper-switch states {A,B,C} |
| sw_lo | output | 3 | Lower-switch states, inverse of sw_hi |
| period_start | output | 1 | One-clock strobe at each period boundary |
| cm_pos | output | 1 | 1 for a positive common-mode level, 0 for negative |

## Verification
A tick counter that is off by one moves both the segment edge and the strobe. The bench sees this within one period, because it compares every cycle of a period with the expected vector and checks the strobe position. If the holding register is loaded at the wrong moment, the new pair shows up in the middle of the current period, or one period late. Each mid-period command test looks at both the tail of the old period and the first cycle after the boundary, so either case is caught. A wrong saturation or illegal-index fallback shows up as the wrong state at the first sampled cycle after the affected segment starts.

// File: rtl/dualvec_pkg.sv
package dualvec_pkg;

  typedef logic [2:0] vec_idx_t;
  typedef logic [2:0] leg_state_t;

  // Bit 2 is phase A, bit 0 is phase C; 1 means the upper switch is closed.
  localparam leg_state_t RESET_STATE = 3'b100;

  function automatic logic idx_legal(input vec_idx_t idx);
    return (idx != 3'd0) && (idx != 3'd7);
  endfunction

  function automatic leg_state_t idx_to_state(input vec_idx_t idx);
    leg_state_t s;
    case (idx)
      3'd1:    s = 3'b100;
      3'd2:    s = 3'b110;
      3'd3:    s = 3'b010;
      3'd4:    s = 3'b011;
      3'd5:    s = 3'b001;
      3'd6:    s = 3'b101;
      default: s = 3'b000;
    endcase
    return s;
  endfunction

  // Majority of three legs: for an active state this is "two legs high".
  function automatic logic two_high(input leg_state_t s);
    return (s[0] & s[1]) | (s[1] & s[2]) | (s[0] & s[2]);
  endfunction

endpackage

// File: rtl/dualvec_cmd_stage.sv
module dualvec_cmd_stage
  import dualvec_pkg::*;
#(
  parameter int T1_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  vec_idx_t        in_first,
  input  vec_idx_t        in_second,
  input  logic [T1_W-1:0] in_t1,
  input  logic            take,
  output logic            pend_valid,
  output vec_idx_t        pend_first,
  output vec_idx_t        pend_second,
  output logic [T1_W-1:0] pend_t1
);

  logic            full_q;
  vec_idx_t        first_q;
  vec_idx_t        second_q;
  logic [T1_W-1:0] t1_q;
  logic            accept;

  assign accept   = in_valid && !full_q;
  assign in_ready = !full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (accept) begin
      full_q <= 1'b1;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q  <= '0;
      second_q <= '0;
      t1_q     <= '0;
    end else if (accept) begin
      first_q  <= in_first;
      second_q <= in_second;
      t1_q     <= in_t1;
    end
  end

  assign pend_valid  = full_q;
  assign pend_first  = first_q;
  assign pend_second = second_q;
  assign pend_t1     = t1_q;

  // R5: one accepted command closes the port until the boundary drains it
  a_r5_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r5_held_until_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && !take) |=> pend_valid);

endmodule

// File: rtl/dualvec_seg_timer.sv
module dualvec_seg_timer #(
  parameter int PERIOD_TICKS = 10,
  parameter int CNT_W        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] split,
  output logic             boundary,
  output logic             switch_pt
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;
  logic             at_last;

  assign at_last   = (cnt_q == LAST);
  assign cnt_inc   = {1'b0, cnt_q} + 1'b1;
  assign boundary  = tick && at_last;
  assign switch_pt = tick && !at_last && (cnt_inc == {1'b0, split});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (boundary) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_inc[CNT_W-1:0];
    end
  end

  // R3: the tick counter never leaves the period
  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R3: a segment change never coincides with a period boundary
  a_r3_switch_not_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !(boundary && switch_pt));

endmodule

// File: rtl/dualvec_leg_driver.sv
module dualvec_leg_driver
  import dualvec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       restart,
  input  vec_idx_t   seg_idx,
  output leg_state_t hi,
  output leg_state_t lo,
  output logic       strobe,
  output logic       cm_pos
);

  leg_state_t hi_q;
  logic       strobe_q;
  logic       seg_ok;

  assign seg_ok = idx_legal(seg_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q     <= RESET_STATE;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= restart;
      if (load && seg_ok) begin
        hi_q <= idx_to_state(seg_idx);
      end
    end
  end

  for (genvar p = 0; p < 3; p++) begin : g_leg
    assign lo[p] = ~hi_q[p];
  end

  assign hi     = hi_q;
  assign strobe = strobe_q;
  assign cm_pos = two_high(hi_q);

  // R2: only active states reach the legs
  a_r2_active_only: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_q != 3'b000) && (hi_q != 3'b111));

  // R8: an illegal index leaves the legs where they were
  a_r8_illegal_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !seg_ok) |=> $stable(hi_q));

  // R4: strobe is a single-cycle pulse
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q);

endmodule

// File: rtl/dualvec_sequencer.sv
module dualvec_sequencer
  import dualvec_pkg::*;
#(
  parameter  int PERIOD_TICKS = 10,
  localparam int T1_W         = $clog2(PERIOD_TICKS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_first,
  input  logic [2:0]      cmd_second,
  input  logic [T1_W-1:0] cmd_t1,
  output logic [2:0]      sw_hi,
  output logic [2:0]      sw_lo,
  output logic            period_start,
  output logic            cm_pos
);

  localparam logic [T1_W:0]   N_EXT     = (T1_W + 1)'(PERIOD_TICKS);
  localparam logic [T1_W-1:0] SPLIT_MAX = T1_W'(PERIOD_TICKS - 1);
  localparam logic [T1_W-1:0] SPLIT_RST = T1_W'(PERIOD_TICKS / 2);

  function automatic logic [T1_W-1:0] clamp_split(input logic [T1_W-1:0] raw);
    if (raw == '0) begin
      return T1_W'(1);
    end else if ({1'b0, raw} >= N_EXT) begin
      return SPLIT_MAX;
    end else begin
      return raw;
    end
  endfunction

  logic            pend_valid;
  vec_idx_t        pend_first;
  vec_idx_t        pend_second;
  logic [T1_W-1:0] pend_t1;
  logic            boundary;
  logic            switch_pt;

  vec_idx_t        act_first_q;
  vec_idx_t        act_second_q;
  logic [T1_W-1:0] act_split_q;
  vec_idx_t        nxt_first;
  vec_idx_t        seg_idx;

  dualvec_cmd_stage #(.T1_W(T1_W)) u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (cmd_valid),
    .in_ready    (cmd_ready),
    .in_first    (cmd_first),
    .in_second   (cmd_second),
    .in_t1       (cmd_t1),
    .take        (boundary),
    .pend_valid  (pend_valid),
    .pend_first  (pend_first),
    .pend_second (pend_second),
    .pend_t1     (pend_t1)
  );

  dualvec_seg_timer #(.PERIOD_TICKS(PERIOD_TICKS), .CNT_W(T1_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .split     (act_split_q),
    .boundary  (boundary),
    .switch_pt (switch_pt)
  );

  // Active pair: replaced only at a boundary that finds a pending command.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_first_q  <= 3'd1;
      act_second_q <= 3'd1;
      act_split_q  <= SPLIT_RST;
    end else if (boundary && pend_valid) begin
      act_first_q  <= pend_first;
      act_second_q <= pend_second;
      act_split_q  <= clamp_split(pend_t1);
    end
  end

  assign nxt_first = pend_valid ? pend_first : act_first_q;
  assign seg_idx   = boundary ? nxt_first : act_second_q;

  dualvec_leg_driver u_legs (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (boundary || switch_pt),
    .restart (boundary),
    .seg_idx (seg_idx),
    .hi      (sw_hi),
    .lo      (sw_lo),
    .strobe  (period_start),
    .cm_pos  (cm_pos)
  );

  // R3: without a tick nothing moves
  a_r3_idle_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(sw_hi) && !period_start));

  // R7: the applied split always leaves both segments non-empty
  a_r7_split_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (act_split_q != '0) && (act_split_q <= SPLIT_MAX));

  // R6: the pair only changes at a boundary
  a_r6_pair_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> ($stable(act_first_q) && $stable(act_second_q) && $stable(act_split_q)));

endmodule

// File: tb/dualvec_sequencer_bench.sv
module dualvec_sequencer_bench;

  localparam int N  = 10;
  localparam int TW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_first = '0;
  logic [2:0]    cmd_second = '0;
  logic [TW-1:0] cmd_t1 = '0;
  logic          cmd_ready;
  logic [2:0]    sw_hi;
  logic [2:0]    sw_lo;
  logic          period_start;
  logic          cm_pos;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  dualvec_sequencer #(.PERIOD_TICKS(N)) u_dualvec_sequencer (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_first    (cmd_first),
    .cmd_second   (cmd_second),
    .cmd_t1       (cmd_t1),
    .sw_hi        (sw_hi),
    .sw_lo        (sw_lo),
    .period_start (period_start),
    .cm_pos       (cm_pos)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] ref_state(input int v);
    case (v)
      1: return 3'b100;
      2: return 3'b110;
      3: return 3'b010;
      4: return 3'b011;
      5: return 3'b001;
      6: return 3'b101;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic ref_cm(input logic [2:0] s);
    return $countones(s) == 2;
  endfunction

  // One sample at cycle j of a period (j = 0 is the strobe cycle).
  task automatic sample(input int j, input logic [2:0] exp, input string req);
    check(sw_hi == exp, req, sw_hi, exp);
    check(sw_lo == ~exp, "R9 complement", sw_lo, ~exp);
    check(cm_pos == ref_cm(exp), "R10 cm sign", cm_pos, ref_cm(exp));
    check(period_start == (j == 0), "R4 strobe", period_start, (j == 0));
  endtask

  task automatic check_segments(input int start_j, input logic [2:0] first, input logic [2:0] second,
                                input int t1, input string req);
    for (int j = start_j; j < N; j++) begin
      if (j != start_j) @(negedge clk);
      sample(j, (j < t1) ? first : second, req);
    end
  endtask

  task automatic sync_strobe();
    @(negedge clk);
    while (!period_start) @(negedge clk);
  endtask

  task automatic send_cmd(input int f, input int s, input int t);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid  = 1'b1;
    cmd_first  = 3'(f);
    cmd_second = 3'(s);
    cmd_t1     = TW'(t);
    @(negedge clk);
    cmd_valid  = 1'b0;
  endtask

  task automatic program_and_check(input int f, input int s, input int t,
                                   input logic [2:0] ef, input logic [2:0] es,
                                   input int eff_t1, input string req);
    sync_strobe();
    repeat (2) @(negedge clk);
    send_cmd(f, s, t);
    check(cmd_ready == 1'b0, "R5 ready low while pending", cmd_ready, 0);
    sync_strobe();
    check(cmd_ready == 1'b1, "R5 ready back after boundary", cmd_ready, 1);
    check_segments(0, ef, es, eff_t1, req);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sw_hi == 3'b100, "R11 reset state", sw_hi, 3'b100);
    check(sw_lo == 3'b011, "R11 reset complement", sw_lo, 3'b011);
    check(period_start == 1'b0, "R11 reset strobe", period_start, 0);
    check(cmd_ready == 1'b1, "R11 reset ready", cmd_ready, 1);
    check(cm_pos == 1'b0, "R11 reset cm", cm_pos, 0);
    tick = 1'b1;
    sync_strobe();
    check_segments(0, 3'b100, 3'b100, N / 2, "R11 default period");
  endtask

  task automatic t_encoding();
    program_and_check(1, 2, 3, ref_state(1), ref_state(2), 3, "R1 pair 1/2");
    program_and_check(3, 4, 5, ref_state(3), ref_state(4), 5, "R1 pair 3/4");
    program_and_check(5, 6, 7, ref_state(5), ref_state(6), 7, "R1 pair 5/6");
  endtask

  task automatic t_repeat();
    sync_strobe();
    check_segments(0, ref_state(5), ref_state(6), 7, "R6 repeat");
  endtask

  task automatic t_midperiod();
    sync_strobe();
    repeat (2) @(negedge clk);
    send_cmd(2, 4, 2);
    check(cmd_ready == 1'b0, "R5 ready low mid-period", cmd_ready, 0);
    check_segments(4, ref_state(5), ref_state(6), 7, "R5 old period untouched");
    sync_strobe();
    check(cmd_ready == 1'b1, "R5 ready after boundary", cmd_ready, 1);
    check_segments(0, ref_state(2), ref_state(4), 2, "R5 new pair at boundary");
  endtask

  task automatic t_saturate();
    program_and_check(3, 1, 0, ref_state(3), ref_state(1), 1, "R7 zero split");
    program_and_check(4, 2, 15, ref_state(4), ref_state(2), N - 1, "R7 large split");
  endtask

  task automatic t_tick_gate();
    logic [2:0] held;
    sync_strobe();
    repeat (8) @(negedge clk);
    tick = 1'b0;
    held = sw_hi;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(sw_hi == held, "R3 no tick no change", sw_hi, held);
      check(period_start == 1'b0, "R3 no tick no strobe", period_start, 0);
    end
    tick = 1'b1;
    @(negedge clk);
    check_segments(9, ref_state(4), ref_state(2), N - 1, "R3 period resumes");
    sync_strobe();
    check_segments(0, ref_state(4), ref_state(2), N - 1, "R3 full period after stall");
  endtask

  task automatic t_illegal();
    program_and_check(0, 3, 4, ref_state(2), ref_state(3), 4, "R8 illegal first");
    program_and_check(2, 7, 6, ref_state(2), ref_state(2), 6, "R8 illegal second");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_encoding();
    t_repeat();
    t_midperiod();
    t_saturate();
    t_tick_gate();
    t_illegal();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule